// File: doc/BRIEF.md
# Pulse Burst Rate Multiplier

This block raises the rate of a slow pulse train by a factor of 2, 4 or 8. Each rising edge on an asynchronous input starts a burst of a fixed number of output pulses. The pulses are taken from an internal tick source that runs freely at one tick every `div_i` system clocks. A cleared burst counter opens a gate on that tick stream. The gate closes again when the counter bit picked by the factor select goes high.

Everything runs on one system clock. The input passes through a two-flop synchroniser. A rising-edge detector then makes a single-cycle start pulse, whatever the width of the input pulse. Bursts only come out whole when the tick source is at least ten times faster than the input rate. If an edge arrives during a burst, the count restarts, and a one-cycle overrun flag reports the overlap.

Top module: `pulse_burst_mult`

## Requirements
- R1: Each rising edge of `pulse_in` produces exactly one burst, however long the input stays high.
- R2: Burst length follows `factor_sel`: 2'b01 gives 2 pulses, 2'b10 gives 4 pulses and 2'b11 gives 8 pulses.
- R3: `factor_sel` = 2'b00 gives a burst of 2 pulses.
- R4: Each output pulse is one clock wide. Consecutive pulses of a burst are spaced `div_i` clocks apart.
- R5: A `div_i` value below 2 is handled as 2, so the pulse spacing becomes 2 clocks.
- R6: `busy_o` rises with the start of a burst and falls on the cycle the last pulse appears. No pulse appears while the block is idle.
- R7: An edge that arrives during a burst restarts the count and raises `overrun_o` for one cycle. Exactly one full burst of pulses follows that cycle.
- R8: `factor_sel` is captured when a burst starts. Changing it during the burst has no effect on the pulse count.
- R9: After reset, `busy_o`, `pulse_o` and `overrun_o` stay low until the first input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | Asynchronous input pulse train |
| factor_sel | input | 2 | Multiplication factor select (00/01 x2, 10 x4, 11 x8) |
| div_i | input | DIV_W | Tick source period in clocks (minimum 2) |
| pulse_o | output | 1 | Output pulse stream, one clock per pulse |
| busy_o | output | 1 | High while a burst is in progress |
| overrun_o | output | 1 | One-cycle flag: an edge arrived during a burst |

## Verification
The assertions assume that `div_i` is not changed in the middle of a burst. They also assume that input edges arrive no faster than the synchroniser can resolve them, meaning the input holds each level for at least two clocks. The stimulus holds `div_i` constant within each scenario. It keeps every input level for several clocks and leaves gaps between edges that are longer than a full burst, except in the retrigger scenario, which puts its second edge into an open burst on purpose.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int MAX_LOG = 3;
  localparam int CNT_W   = MAX_LOG + 1;

  typedef enum logic [1:0] {
    SEL_X2_ALT = 2'b00,
    SEL_X2     = 2'b01,
    SEL_X4     = 2'b10,
    SEL_X8     = 2'b11
  } factor_e;

  function automatic int unsigned term_bit(input factor_e s);
    case (s)
      SEL_X8:  term_bit = 3;
      SEL_X4:  term_bit = 2;
      default: term_bit = 1;
    endcase
  endfunction
endpackage

// File: rtl/pbm_edge_start.sv
module pbm_edge_start (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic start_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b0;
      s2      <= 1'b0;
      s3      <= 1'b0;
      start_o <= 1'b0;
    end else begin
      s1      <= async_i;
      s2      <= s1;
      s3      <= s2;
      start_o <= s2 & ~s3;
    end
  end

  // R1: a start pulse never lasts longer than one cycle
  p_start_single_r1: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
endmodule

// File: rtl/pbm_tick_gen.sv
module pbm_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb lim = (div_i < DIV_W'(2)) ? DIV_W'(1) : div_i - DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (cnt >= lim) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + DIV_W'(1);
      tick_o <= 1'b0;
    end
  end

  // R5: spacing never drops below two clocks, so ticks are never adjacent
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pbm_burst_ctrl.sv
module pbm_burst_ctrl
  import pbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       tick_i,
  input  factor_e    sel_i,
  output logic       pulse_o,
  output logic       busy_o,
  output logic       overrun_o
);
  logic [CNT_W-1:0] cnt;
  factor_e          sel_q;
  logic             open;

  always_comb open = ~cnt[term_bit(sel_q)];
  always_comb busy_o = open;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '1;
      sel_q     <= SEL_X2;
      pulse_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= start_i & open;
      pulse_o   <= tick_i & open & ~start_i;
      if (start_i) begin
        cnt   <= '0;
        sel_q <= sel_i;
      end else if (tick_i && open) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R6: a start always leaves the burst in progress
  p_start_opens_r6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_o);
  // R6: an idle block with no start emits nothing next cycle
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> !pulse_o);
  // R8: the captured factor holds for the whole burst
  p_sel_held_r8: assert property (@(posedge clk) disable iff (rst)
    (!start_i) |=> $stable(sel_q));
  // R7: overrun only reports a start that hit an open burst
  p_overrun_cause_r7: assert property (@(posedge clk) disable iff (rst)
    overrun_o |-> $past(start_i));
endmodule

// File: rtl/pulse_burst_mult.sv
module pulse_burst_mult
  import pbm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_in,
  input  logic [1:0]       factor_sel,
  input  logic [DIV_W-1:0] div_i,
  output logic             pulse_o,
  output logic             busy_o,
  output logic             overrun_o
);
  logic start, tick;

  pbm_edge_start u_edge (
    .clk     (clk),
    .rst     (rst),
    .async_i (pulse_in),
    .start_o (start)
  );

  pbm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .div_i  (div_i),
    .tick_o (tick)
  );

  pbm_burst_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .tick_i    (tick),
    .sel_i     (factor_e'(factor_sel)),
    .pulse_o   (pulse_o),
    .busy_o    (busy_o),
    .overrun_o (overrun_o)
  );

  // R4: output pulses are one clock wide
  p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  // R9: first cycle after reset is quiet
  p_reset_quiet_r9: assert property (@(posedge clk)
    $fell(rst) |-> (!pulse_o && !overrun_o && !busy_o));
endmodule

// File: tb/pulse_burst_mult_bench.sv
module pulse_burst_mult_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst = 1'b1, pulse_in = 1'b0;
  logic [1:0] factor_sel = 2'b01;
  logic [DIV_W-1:0] div_i = 8'd4;
  logic pulse_o, busy_o, overrun_o;

  int n_chk = 0, n_bad = 0;
  int pcount = 0, post_ovr = 0, ovr_cnt = 0, stray = 0, wide = 0;
  int cyc = 0, last_p = -1, gap_min = 1000, gap_max = 0;
  logic prev_p = 1'b0, prev_b = 1'b0, ovr_armed = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_burst_mult #(.DIV_W(DIV_W)) u_pulse_burst_mult (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .factor_sel(factor_sel),
    .div_i(div_i), .pulse_o(pulse_o), .busy_o(busy_o), .overrun_o(overrun_o)
  );

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (pulse_o) begin
        pcount++;
        if (ovr_armed) post_ovr++;
        if (last_p >= 0) begin
          if (cyc - last_p < gap_min) gap_min = cyc - last_p;
          if (cyc - last_p > gap_max) gap_max = cyc - last_p;
        end
        last_p = cyc;
        if (prev_p) wide++;
        if (!busy_o && !prev_b) stray++;
      end
      if (overrun_o) begin ovr_cnt++; ovr_armed = 1'b1; end
      prev_p = pulse_o;
      prev_b = busy_o;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    pcount = 0; post_ovr = 0; ovr_cnt = 0; stray = 0; wide = 0;
    last_p = -1; gap_min = 1000; gap_max = 0; ovr_armed = 1'b0;
  endtask

  task automatic fire(input int width);
    pulse_in = 1'b1;
    repeat (width) @(negedge clk);
    pulse_in = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    clear_mon();
    check("R9 busy after reset", int'(busy_o), 0);
    repeat (30) @(negedge clk);
    check("R9 no pulses before edge", pcount, 0);
    check("R9 no overrun", ovr_cnt, 0);
  endtask

  task automatic t_factor(input logic [1:0] sel, input int exp, input string req);
    factor_sel = sel; div_i = 8'd4;
    clear_mon();
    fire(3);
    repeat (60) @(negedge clk);
    check(req, pcount, exp);
    check({req, " spacing min"}, gap_min, 4);
    check({req, " spacing max"}, gap_max, 4);
    check("R4 width", wide, 0);
    check("R6 stray", stray, 0);
    check("R6 idle", int'(busy_o), 0);
  endtask

  task automatic t_wide();
    factor_sel = 2'b10; div_i = 8'd3;
    clear_mon();
    fire(80);
    repeat (40) @(negedge clk);
    check("R1 long input one burst", pcount, 4);
  endtask

  task automatic t_clamp(input logic [DIV_W-1:0] d, input int exp_gap);
    factor_sel = 2'b11; div_i = d;
    clear_mon();
    fire(2);
    repeat (60) @(negedge clk);
    check("R5 clamp count", pcount, 8);
    check("R5 spacing", gap_max, exp_gap);
  endtask

  task automatic t_busy();
    int seen_busy = 0;
    factor_sel = 2'b10; div_i = 8'd5;
    clear_mon();
    fire(2);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (busy_o) seen_busy = 1;
    end
    check("R6 busy during burst", seen_busy, 1);
    repeat (40) @(negedge clk);
    check("R6 busy falls", int'(busy_o), 0);
    check("R6 count", pcount, 4);
  endtask

  task automatic t_retrigger();
    factor_sel = 2'b11; div_i = 8'd4;
    clear_mon();
    fire(2);
    repeat (10) @(negedge clk);
    fire(2);
    repeat (60) @(negedge clk);
    check("R7 overrun count", ovr_cnt, 1);
    check("R7 pulses after restart", post_ovr, 8);
    check("R6 stray", stray, 0);
  endtask

  task automatic t_sel_change();
    factor_sel = 2'b01; div_i = 8'd6;
    clear_mon();
    fire(2);
    repeat (6) @(negedge clk);
    factor_sel = 2'b11;
    repeat (60) @(negedge clk);
    check("R8 sel ignored mid-burst", pcount, 2);
    check("R8 no overrun", ovr_cnt, 0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_factor(2'b01, 2, "R2 x2");
    t_factor(2'b10, 4, "R2 x4");
    t_factor(2'b11, 8, "R2 x8");
    t_factor(2'b00, 2, "R3 sel 00");
    t_wide();
    t_clamp(8'd0, 2);
    t_clamp(8'd1, 2);
    t_clamp(8'd5, 5);
    t_busy();
    t_retrigger();
    t_sel_change();
    finish_run();
  end
endmodule